// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a synchronous host and an external asynchronous static RAM that holds 512K words of 16 bits. The host issues one word request at a time over a valid/ready handshake. Each request carries a word address, write data, a two-lane byte mask and a write flag. The controller turns the request into address, chip-enable, output-enable, write-enable and byte-lane strobes, and holds each one for a whole number of clock cycles. Read data comes back with a single-cycle valid pulse.

All analog timing limits are given as nanosecond parameters. Each limit is turned into a cycle count: the value divided by the clock period, rounded up, and never less than one. A read holds its strobes for the longer of the address-access and output-enable limits. A write holds its strobes for the longest of the pulse-width, cycle-time, address-to-end and data-setup limits. After a read, the memory may keep driving the shared data lines for a short time. The controller therefore waits out a turnaround gap before it drives those lines for a write.

The data bus is split into an output value, an output enable and an input value. Pad logic outside the block combines them into a tri-state bus.

Top module: `sram_ctl`

## Requirements
- R1: While reset is held and on the first cycle after it, `req_ready` is 1, `rsp_valid` is 0, `mem_ce_n`, `mem_oe_n`, `mem_we_n`, `mem_lb_n` and `mem_ub_n` are 1, and `mem_ce` and `mem_dq_oe` are 0. A reset during an access abandons that access.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from that edge until the access has ended.
- R3: A read sets `mem_we_n` to 1 and `mem_oe_n` to 0, with both chip enables active (`mem_ce_n`=0, `mem_ce`=1). It holds this for exactly ceil(70 ns / period) cycles, which is 7 at a 10 ns period. `mem_addr` equals the request address and stays stable throughout.
- R4: The read word is sampled on the final cycle of the read. `rsp_valid` is 1 for exactly one cycle, the 8th cycle after the accepting edge at a 10 ns period. A lane whose mask bit is 0 returns zeros in `rsp_rdata`. A write never raises `rsp_valid`.
- R5: A write keeps `mem_oe_n` at 1 and sets `mem_we_n` to 0 with both chip enables active. It holds this for exactly the largest of ceil(50), ceil(70), ceil(60) and ceil(30) ns / period, which is 7 cycles at 10 ns. `mem_addr` and `mem_dq_out` stay stable throughout.
- R6: Mask bit 0 drives `mem_lb_n` low and selects data bits 7:0. Mask bit 1 drives `mem_ub_n` low and selects bits 15:8. A lane whose mask bit is 0 is neither written nor read. A mask of 00 leaves the memory contents unchanged.
- R7: Between two accesses the chip enables return to their inactive levels for at least one cycle. With back-to-back requests and no turnaround, that idle time is exactly one cycle.
- R8: `mem_dq_oe` rises no sooner than ceil(25 ns / period) cycles after `mem_oe_n` rises, which is 3 at 10 ns. A write that directly follows a read waits exactly that long, while a write after a write waits no extra cycles.
- R9: `mem_dq_oe` is 1 only while `mem_we_n` is 0, and never while `mem_oe_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_rdata | output | 16 | Read data, unmasked lanes zeroed |
| mem_addr | output | 19 | Memory address |
| mem_ce_n | output | 1 | Active-low chip enable |
| mem_ce | output | 1 | Active-high chip enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_lb_n | output | 1 | Active-low lower lane enable |
| mem_ub_n | output | 1 | Active-low upper lane enable |
| mem_dq_out | output | 16 | Data to drive onto the bus |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_in | input | 16 | Data sampled from the bus |

## Verification
If the cycle counter is off by one, the strobe run length at the memory pins changes by a cycle on the very next access. The same error also moves the `rsp_valid` pulse by one cycle. If the turnaround counter reloads wrongly, it shows up only when a write follows a read: the gap between `mem_oe_n` rising and `mem_dq_oe` rising shrinks, or extra cycles are inserted. An error in the lane or capture path appears as corrupted bytes when a word written with a partial mask is read back.

// File: rtl/sram_ctl_pkg.sv
// Shared types and timing helpers for the asynchronous SRAM controller.
// Assumes all timing limits are non-negative integers in ns.
package sram_ctl_pkg;

    localparam int ADDR_W = 19;
    localparam int DATA_W = 16;
    localparam int LANES  = DATA_W / 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_GAP,
        ST_READ,
        ST_WRITE
    } ctl_state_e;

    // Cycles needed to cover a limit: ceiling of ns / period, at least one.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
// Down-counter that times one access phase.
// Loading N makes the phase last N+1 cycles.
// Assumes load is only requested once the previous phase has finished.
module sram_ctl_timer #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);
    logic [W-1:0] cnt;

    // Load on phase start, otherwise count down to zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign last = (cnt == '0);

    AST_TIMER_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !load) |=> last); // R3
endmodule

// File: rtl/sram_ctl_gap.sv
// Turnaround guard. After a read releases output enable, it counts off
// the cycles in which the memory may still drive the data lines.
// ok_next is 1 when data drive may begin on the next clock edge.
module sram_ctl_gap #(
    parameter int TA = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rel,
    input  logic drive,
    output logic ok_next
);
    localparam int GW = $clog2(TA + 1);
    logic [GW-1:0] cnt;

    // Reload when a read ends, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt <= '0;
        else if (rel)       cnt <= GW'(TA);
        else if (cnt != '0) cnt <= cnt - 1'b1;
    end

    assign ok_next = (cnt <= GW'(1));

    AST_GAP_BEFORE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive) |-> $past(ok_next)); // R8
endmodule

// File: rtl/sram_ctl_rdcap.sv
// Read capture. It samples the bus on the last read cycle, zeroes the lanes
// that were not enabled, and raises a one-cycle valid.
module sram_ctl_rdcap
    import sram_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [LANES-1:0]  be,
    input  logic [DATA_W-1:0] din,
    output logic              valid,
    output logic [DATA_W-1:0] rdata
);
    // Valid pulse follows each capture by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) valid <= 1'b0;
        else        valid <= capture;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // Capture one lane, replacing a floating lane with zeros.
        always_ff @(posedge clk) begin
            if (!rst_n)       rdata[8*l +: 8] <= '0;
            else if (capture) rdata[8*l +: 8] <= be[l] ? din[8*l +: 8] : 8'h00;
        end
    end

    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid); // R4
endmodule

// File: rtl/sram_ctl.sv
// Asynchronous SRAM access controller (top).
// Takes one host word request at a time and drives registered memory
// strobes. Every phase length is derived from the ns parameters and CLK_NS.
// Assumes the pads combine mem_dq_out, mem_dq_oe and mem_dq_in into one bus.
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int CLK_NS   = 10,
    parameter int T_AA_NS  = 70,
    parameter int T_OE_NS  = 35,
    parameter int T_WP_NS  = 50,
    parameter int T_WC_NS  = 70,
    parameter int T_AW_NS  = 60,
    parameter int T_DW_NS  = 30,
    parameter int T_HZ_NS  = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_be,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_ce,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int RD_CYC = max_of(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_OE_NS, CLK_NS));
    localparam int WR_CYC = max_of(max_of(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_WC_NS, CLK_NS)),
                                   max_of(ns_to_cyc(T_AW_NS, CLK_NS), ns_to_cyc(T_DW_NS, CLK_NS)));
    localparam int TA_CYC = ns_to_cyc(T_HZ_NS, CLK_NS);
    localparam int CNT_W  = $clog2(max_of(RD_CYC, WR_CYC) + 1);

    ctl_state_e       state;
    logic [LANES-1:0] be_q;
    logic             go_rd, go_wr, rd_end, wr_end, tmr_last, gap_ok;
    logic [LANES-1:0] go_be;

    // Decide which phase starts on this edge and which lanes it uses.
    always_comb begin
        go_rd  = (state == ST_IDLE) && req_valid && !req_write;
        go_wr  = ((state == ST_IDLE) && req_valid && req_write && gap_ok)
               || ((state == ST_GAP) && gap_ok);
        go_be  = (state == ST_IDLE) ? req_be : be_q;
        rd_end = (state == ST_READ)  && tmr_last;
        wr_end = (state == ST_WRITE) && tmr_last;
    end

    assign req_ready = (state == ST_IDLE);

    sram_ctl_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (go_rd || go_wr),
        .load_val (go_rd ? CNT_W'(RD_CYC - 1) : CNT_W'(WR_CYC - 1)),
        .last     (tmr_last)
    );

    sram_ctl_gap #(.TA(TA_CYC)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .rel     (rd_end),
        .drive   (mem_dq_oe),
        .ok_next (gap_ok)
    );

    sram_ctl_rdcap u_rdcap (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (rd_end),
        .be      (be_q),
        .din     (mem_dq_in),
        .valid   (rsp_valid),
        .rdata   (rsp_rdata)
    );

    // Sequence the state and the registered memory strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            be_q       <= '0;
            mem_addr   <= '0;
            mem_dq_out <= '0;
            mem_ce_n   <= 1'b1;
            mem_ce     <= 1'b0;
            mem_oe_n   <= 1'b1;
            mem_we_n   <= 1'b1;
            mem_lb_n   <= 1'b1;
            mem_ub_n   <= 1'b1;
            mem_dq_oe  <= 1'b0;
        end else begin
            if (state == ST_IDLE && req_valid) begin
                be_q       <= req_be;
                mem_addr   <= req_addr;
                mem_dq_out <= req_wdata;
                if (req_write && !gap_ok) state <= ST_GAP;
            end
            if (go_rd || go_wr) begin
                state    <= go_rd ? ST_READ : ST_WRITE;
                mem_ce_n <= 1'b0;
                mem_ce   <= 1'b1;
                mem_oe_n <= !go_rd;
                mem_we_n <= !go_wr;
                mem_dq_oe <= go_wr;
                mem_lb_n <= !go_be[0];
                mem_ub_n <= !go_be[1];
            end
            if (rd_end || wr_end) begin
                state     <= ST_IDLE;
                mem_ce_n  <= 1'b1;
                mem_ce    <= 1'b0;
                mem_oe_n  <= 1'b1;
                mem_we_n  <= 1'b1;
                mem_dq_oe <= 1'b0;
                mem_lb_n  <= 1'b1;
                mem_ub_n  <= 1'b1;
            end
        end
    end

    AST_NO_DRIVE_WITH_OE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_dq_oe && !mem_oe_n)); // R9
    AST_DRIVE_ONLY_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> !mem_we_n); // R9
    AST_WE_OE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_we_n && !mem_oe_n)); // R5
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr)); // R3
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> !req_ready); // R2
    AST_CE_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce == !mem_ce_n); // R7
endmodule

// File: tb/sram_ctl_tb.sv
// Self-checking bench: a vector table of host requests against a small
// memory model, protocol monitors at the pins, then directed corner tests.
module sram_ctl_tb;
    localparam int RD = 7;
    localparam int WR = 7;
    localparam int TA = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        req_ready, rsp_valid;
    logic [15:0] rsp_rdata;
    logic [18:0] mem_addr;
    logic        mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe;
    logic [15:0] mem_dq_out, mem_dq_in;

    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    sram_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_ce(mem_ce), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Memory model: 256 words indexed by the low address bits. Lanes that are
    // not enabled return garbage, and an idle bus reads as garbage.
    logic [15:0] mem [0:255];
    wire active = !mem_ce_n && mem_ce;
    always_comb begin
        if (active && !mem_oe_n && mem_we_n)
            mem_dq_in = {mem_ub_n ? 8'hA5 : mem[mem_addr[7:0]][15:8],
                         mem_lb_n ? 8'h5A : mem[mem_addr[7:0]][7:0]};
        else
            mem_dq_in = 16'hDEAD;
    end

    // Expected request seen by the pin monitors.
    logic [18:0] exp_addr;
    logic [1:0]  exp_be;
    int rd_run = 0, wr_run = 0, idle = 1, gap = 99, last_gap = 0, last_idle = 0;
    logic prev_oe_drv = 1'b0, prev_rsp = 1'b0;
    logic [15:0] wr_data0;

    // Pin monitors and memory writes, evaluated away from the active edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            rd_run = 0; wr_run = 0; idle = 1; gap = 99; prev_oe_drv = 0; prev_rsp = 0;
        end else begin
            if (active) begin
                if (idle > 0) begin
                    chk(idle >= 1, "R7 idle before access", idle, 1);
                    last_idle = idle;
                end
                idle = 0;
                chk(!req_ready, "R2 ready low while busy", req_ready, 0);
                chk(mem_addr == exp_addr, "R3 address", mem_addr, exp_addr);
                chk({mem_ub_n, mem_lb_n} == ~exp_be, "R6 lane enables", {mem_ub_n, mem_lb_n}, ~exp_be);
            end else begin
                idle++;
            end
            if (active && !mem_oe_n) rd_run++;
            else if (rd_run > 0) begin
                chk(rd_run == RD, "R3 read strobe length", rd_run, RD);
                rd_run = 0;
            end
            if (active && !mem_we_n) begin
                if (wr_run == 0) wr_data0 = mem_dq_out;
                wr_run++;
                chk(mem_oe_n && mem_dq_oe, "R5 oe high and data driven", {mem_oe_n, mem_dq_oe}, 2'b11);
                chk(mem_dq_out == wr_data0, "R5 data stable", mem_dq_out, wr_data0);
                if (!mem_lb_n) mem[mem_addr[7:0]][7:0]  = mem_dq_out[7:0];
                if (!mem_ub_n) mem[mem_addr[7:0]][15:8] = mem_dq_out[15:8];
            end else if (wr_run > 0) begin
                chk(wr_run == WR, "R5 write strobe length", wr_run, WR);
                wr_run = 0;
            end
            if (mem_dq_oe && !prev_oe_drv) begin
                chk(gap >= TA, "R8 turnaround gap", gap, TA);
                last_gap = gap;
            end
            if (!mem_oe_n) gap = 0;
            else if (!mem_dq_oe && gap < 99) gap++;
            chk(!(mem_dq_oe && (mem_we_n || !mem_oe_n)), "R9 drive only in write",
                {mem_dq_oe, mem_we_n, mem_oe_n}, 3'b001);
            if (rsp_valid && prev_rsp) chk(0, "R4 valid longer than one cycle", 2, 1);
            prev_oe_drv = mem_dq_oe;
            prev_rsp = rsp_valid;
        end
    end

    // Issue one request and wait for its completion.
    task automatic do_req(input bit wr, input logic [1:0] be, input logic [7:0] a,
                          input logic [15:0] wd, input logic [15:0] exp_rd);
        int n;
        while (!req_ready) @(negedge clk);
        exp_addr = {11'h5A3, a};
        exp_be = be;
        req_valid = 1; req_write = wr; req_be = be; req_addr = exp_addr; req_wdata = wd;
        @(negedge clk);
        req_valid = 0;
        chk(!req_ready, "R2 ready drops after accept", req_ready, 0);
        n = 1;
        if (!wr) begin
            while (!rsp_valid && n < 50) begin @(negedge clk); n++; end
            chk(n == RD + 1, "R4 response latency", n, RD + 1);
            chk(rsp_rdata == exp_rd, "R4 R6 read data", rsp_rdata, exp_rd);
        end else begin
            while (!req_ready && n < 50) begin
                chk(!rsp_valid, "R4 no response on write", rsp_valid, 0);
                @(negedge clk); n++;
            end
        end
    endtask

    // {write, mask, addr[7:0], wdata, expected read}
    localparam logic [42:0] VEC [0:11] = '{
        {1'b1, 2'b11, 8'h10, 16'h1234, 16'h0000},
        {1'b0, 2'b11, 8'h10, 16'h0000, 16'h1234},
        {1'b1, 2'b01, 8'h11, 16'hABCD, 16'h0000},
        {1'b0, 2'b11, 8'h11, 16'h0000, 16'h00CD},
        {1'b1, 2'b10, 8'h11, 16'h56EF, 16'h0000},
        {1'b0, 2'b11, 8'h11, 16'h0000, 16'h56CD},
        {1'b0, 2'b01, 8'h11, 16'h0000, 16'h00CD},
        {1'b0, 2'b10, 8'h11, 16'h0000, 16'h5600},
        {1'b1, 2'b00, 8'h10, 16'hFFFF, 16'h0000},
        {1'b0, 2'b11, 8'h10, 16'h0000, 16'h1234},
        {1'b1, 2'b11, 8'hFF, 16'h8001, 16'h0000},
        {1'b0, 2'b11, 8'hFF, 16'h0000, 16'h8001}
    };

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        chk({req_ready, rsp_valid, mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe}
            == 9'b1_0_1_0_1_1_1_1_0, "R1 reset state",
            {req_ready, rsp_valid, mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe},
            9'b101011110);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready && mem_ce_n && !mem_dq_oe, "R1 idle after reset", {req_ready, mem_ce_n, mem_dq_oe}, 3'b110);

        for (int i = 0; i < 12; i++)
            do_req(VEC[i][42], VEC[i][41:40], VEC[i][39:32], VEC[i][31:16], VEC[i][15:0]);

        // R8: a write directly after a read waits exactly the turnaround.
        do_req(0, 2'b11, 8'hFF, 16'h0, 16'h8001);
        do_req(1, 2'b11, 8'h20, 16'hC0DE, 16'h0);
        chk(last_gap == TA, "R8 exact gap after read", last_gap, TA);
        // R7/R8: write after write has one idle cycle and no extra gap.
        do_req(1, 2'b11, 8'h21, 16'hBEEF, 16'h0);
        chk(last_idle == 1, "R7 single idle between writes", last_idle, 1);
        // R7: read after read also has exactly one idle cycle.
        do_req(0, 2'b11, 8'h20, 16'h0, 16'hC0DE);
        do_req(0, 2'b11, 8'h21, 16'h0, 16'hBEEF);
        chk(last_idle == 1, "R7 single idle between reads", last_idle, 1);

        // R1: reset in the middle of a read abandons it.
        exp_addr = {11'h5A3, 8'h20}; exp_be = 2'b11;
        req_valid = 1; req_write = 0; req_be = 2'b11; req_addr = exp_addr;
        @(negedge clk);
        req_valid = 0;
        repeat (2) @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        chk(req_ready && mem_ce_n && !mem_ce && mem_oe_n && !rsp_valid, "R1 reset mid-read",
            {req_ready, mem_ce_n, mem_ce, mem_oe_n, rsp_valid}, 5'b11010);
        rst_n = 1;
        repeat (12) begin
            @(negedge clk);
            if (rsp_valid) chk(0, "R1 abandoned read responded", 1, 0);
        end
        do_req(0, 2'b11, 8'h21, 16'h0, 16'hBEEF);
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule